// File: doc/BRIEF.md
# Gate Driver Fault Reaction Controller

This block is the protection state machine for one channel of a power-switch gate driver. It sits between the PWM command and the analog output stage. The PWM reaches the output only while the channel is healthy. A desaturation or overcurrent flag counts only after a blanking window that follows each turn-on edge. An overtemperature flag counts at any time while the channel runs. A confirmed trip takes a one-cycle decision step. The channel then performs a two-stage controlled turn-off: a fast pull-down, then a gentle tail. After that it waits for an off-confirm input, which stands in for the gate voltage having fallen below the safe level.

Once the channel is off, it either stays latched until an explicit clear or, when built for auto-retry, makes a bounded number of restart attempts, each preceded by a cooldown. A hard-disable input and a supply-ok input from the undervoltage supervisor each override every state. Either one cuts the drive in the same cycle and parks the channel off. A Miller-clamp enable, an active-low fault output that stays stable for the whole of each event, a state code and a sticky off-confirm timeout flag report what the channel is doing.

Top module: `gate_fault_ctrl`

## Requirements
- R1: `stateCode` reports the state as RUN=0, FAULT_DETECT=1, SOFT_OFF=2, LATCHED_OFF=3, RECOVERY=4. `driveOut` equals `pwmIn` only in RUN with `disableN` and `supplyOk` both high, and is 0 otherwise.
- R2: With `disableN` low, `driveOut` is 0 in the same cycle and `stateCode` is 3 from the next cycle, whatever the state. Returning `disableN` high does not restart the channel, in either retry or latch mode.
- R3: `scFlag` is ignored while `driveOut` is low and during the first BLANK_CYC high cycles of each drive pulse. `scFlag` high in a later high cycle, or `otFlag` high in any RUN cycle, gives `stateCode` 1 in the next cycle.
- R4: FAULT_DETECT lasts one cycle and is followed by SOFT_OFF. In SOFT_OFF, `fastPull` is high for FAST_CYC cycles, then `softTail` is high for TAIL_CYC cycles. The two are never high together.
- R5: After the tail, SOFT_OFF moves to LATCHED_OFF in the cycle after one in which `offConfirm` is high, and not before.
- R6: In retry mode, LATCHED_OFF reached through a trip moves to RECOVERY in the next cycle. Only RETRY_MAX such attempts are made between clears; after that the channel stays in LATCHED_OFF.
- R7: RECOVERY lasts COOL_CYC cycles. It then moves to RUN if `scFlag` and `otFlag` are both low, and to LATCHED_OFF otherwise.
- R8: In latch mode, LATCHED_OFF is left only through a qualified clear.
- R9: A clear is qualified when `clearReq` is high in LATCHED_OFF while `disableN` and `supplyOk` are high and `scFlag` and `otFlag` are low. A qualified clear gives RUN in the next cycle and resets the attempt count and the timeout flag. A clear that is not qualified has no effect.
- R10: `supplyOk` low acts exactly as `disableN` low.
- R11: `clampEn` is high whenever `driveOut` is low and the state is neither FAULT_DETECT nor SOFT_OFF.
- R12: `faultN` falls in the first FAULT_DETECT cycle of a trip and stays low until the channel next enters RUN. It makes one assertion per event, with no toggling in between.
- R13: `confirmTimeout` goes high in the cycle after the channel is still in SOFT_OFF, with `offConfirm` low, CONFIRM_CYC cycles after the tail ended. It stays high until a qualified clear.
- R14: After reset, `stateCode` is 3, `faultN` is 1 and `confirmTimeout` is 0, and no restart attempt is made until a trip has happened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwmIn | input | 1 | PWM command |
| scFlag | input | 1 | Desaturation / overcurrent comparator flag |
| otFlag | input | 1 | Overtemperature flag |
| disableN | input | 1 | Active-low hard disable |
| supplyOk | input | 1 | Supply valid from undervoltage supervisor |
| clearReq | input | 1 | Request to leave the latched-off state |
| offConfirm | input | 1 | Gate is below the safe level |
| driveOut | output | 1 | Gated drive command to the output stage |
| fastPull | output | 1 | Selects the fast pull-down turn-off stage |
| softTail | output | 1 | Selects the gentle tail turn-off stage |
| clampEn | output | 1 | Miller-clamp enable |
| faultN | output | 1 | Active-low fault report |
| stateCode | output | 3 | Current state code |
| confirmTimeout | output | 1 | Sticky flag: off-confirm came late |

## Verification
The bench builds two copies of the block side by side: one in auto-retry mode and one in latch mode. Both use very short timings: a blanking of 3 cycles, stage lengths of 2 and 3 cycles, an off-confirm window of 4 cycles, a cooldown of 5 cycles and a limit of 2 attempts. These short settings make every part of a fault cycle reachable within a few dozen cycles. That includes the exact blanking edge, the confirm timeout, exhausting the attempt limit and a recovery that fails because a flag is still high. Random traffic can therefore cross many full trip-and-recover cycles in one short run.

// File: rtl/gfr_pkg.sv
package gfr_pkg;

  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_DETECT  = 3'd1,
    ST_SOFTOFF = 3'd2,
    ST_HOLDOFF = 3'd3,
    ST_RECOVER = 3'd4
  } chanState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic restartTmr;
    logic incRetry;
    logic clrRetry;
    logic setFault;
    logic clrFault;
    logic clrTimeout;
  } dpCmd_t;

  // status returned to control
  typedef struct packed {
    logic blankDone;
    logic tailDone;
    logic coolDone;
    logic retryLeft;
  } dpStat_t;

endpackage

// File: rtl/gfr_datapath.sv
module gfr_datapath
  import gfr_pkg::*;
#(
  parameter int unsigned BLANK_CYC   = 40,
  parameter int unsigned FAST_CYC    = 8,
  parameter int unsigned TAIL_CYC    = 60,
  parameter int unsigned CONFIRM_CYC = 200,
  parameter int unsigned COOL_CYC    = 5000,
  parameter int unsigned RETRY_MAX   = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    driveOut,
  input  logic    inSoftOff,
  input  logic    offConfirm,
  input  dpCmd_t  cmd,
  output dpStat_t stat,
  output logic    fastActive,
  output logic    tailActive,
  output logic    faultLatched,
  output logic    confirmTimeout
);

  localparam int unsigned SOFT_END = FAST_CYC + TAIL_CYC;
  localparam int unsigned TO_END   = SOFT_END + CONFIRM_CYC;
  localparam int unsigned TMR_MAX  = (TO_END > COOL_CYC) ? TO_END : COOL_CYC;
  localparam int unsigned TMR_W    = $clog2(TMR_MAX + 2);
  localparam int unsigned ON_W     = $clog2(BLANK_CYC + 2);
  localparam int unsigned RET_W    = $clog2(RETRY_MAX + 2);

  localparam logic [TMR_W-1:0] FAST_T   = TMR_W'(FAST_CYC);
  localparam logic [TMR_W-1:0] SOFT_T   = TMR_W'(SOFT_END);
  localparam logic [TMR_W-1:0] TO_T     = TMR_W'(TO_END);
  localparam logic [TMR_W-1:0] COOL_T   = TMR_W'(COOL_CYC - 1);
  localparam logic [TMR_W-1:0] TMAX_T   = TMR_W'(TMR_MAX);
  localparam logic [ON_W-1:0]  BLANK_T  = ON_W'(BLANK_CYC);
  localparam logic [RET_W-1:0] RETRY_T  = RET_W'(RETRY_MAX);

  logic [TMR_W-1:0] tmr;
  logic [ON_W-1:0]  onCnt;
  logic [RET_W-1:0] retryCnt;
  logic             confirmLate;

  // cycles spent in the current state, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               tmr <= '0;
    else if (cmd.restartTmr) tmr <= '0;
    else if (tmr != TMAX_T)  tmr <= tmr + 1'b1;
  end

  // on-time of the present drive pulse, saturating at the blanking length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                onCnt <= '0;
    else if (!driveOut)       onCnt <= '0;
    else if (onCnt != BLANK_T) onCnt <= onCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             retryCnt <= '0;
    else if (cmd.clrRetry) retryCnt <= '0;
    else if (cmd.incRetry) retryCnt <= retryCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             faultLatched <= 1'b0;
    else if (cmd.setFault) faultLatched <= 1'b1;
    else if (cmd.clrFault) faultLatched <= 1'b0;
  end

  assign confirmLate = tmr >= TO_T;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                         confirmTimeout <= 1'b0;
    else if (cmd.clrTimeout)                           confirmTimeout <= 1'b0;
    else if (inSoftOff && confirmLate && !offConfirm)  confirmTimeout <= 1'b1;
  end

  assign fastActive     = tmr < FAST_T;
  assign tailActive     = (tmr >= FAST_T) && (tmr < SOFT_T);
  assign stat.tailDone  = tmr >= SOFT_T;
  assign stat.coolDone  = tmr >= COOL_T;
  assign stat.blankDone = onCnt == BLANK_T;
  assign stat.retryLeft = retryCnt < RETRY_T;

  AST_RETRY_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    retryCnt <= RETRY_T);  // R6
  AST_TIMEOUT_FROM_SOFTOFF: assert property (@(posedge clk) disable iff (!rstN)
    $rose(confirmTimeout) |-> $past(inSoftOff && !offConfirm));  // R13
  AST_BLANK_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    !driveOut |=> !stat.blankDone);  // R3

endmodule

// File: rtl/gfr_ctrl.sv
module gfr_ctrl
  import gfr_pkg::*;
#(
  parameter bit AUTO_RETRY = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwmIn,
  input  logic       scFlag,
  input  logic       otFlag,
  input  logic       disableN,
  input  logic       supplyOk,
  input  logic       clearReq,
  input  logic       offConfirm,
  input  dpStat_t    stat,
  output chanState_e state,
  output dpCmd_t     cmd,
  output logic       driveOut
);

  chanState_e nextState;
  logic permit, clearOk, scTrip, autoOk, retryAllowed;

  assign permit       = disableN && supplyOk;
  assign clearOk      = clearReq && permit && !scFlag && !otFlag;
  assign driveOut     = (state == ST_RUN) && pwmIn && permit;
  assign scTrip       = driveOut && stat.blankDone && scFlag;
  assign retryAllowed = AUTO_RETRY && autoOk && stat.retryLeft;

  always_comb begin
    nextState      = state;
    cmd            = '0;
    if (!permit) begin
      nextState = ST_HOLDOFF;
    end else begin
      unique case (state)
        ST_RUN:     if (scTrip || otFlag) nextState = ST_DETECT;
        ST_DETECT:  nextState = ST_SOFTOFF;
        ST_SOFTOFF: if (stat.tailDone && offConfirm) nextState = ST_HOLDOFF;
        ST_HOLDOFF: begin
          if (clearOk) begin
            nextState      = ST_RUN;
            cmd.clrRetry   = 1'b1;
            cmd.clrTimeout = 1'b1;
          end else if (retryAllowed) begin
            nextState    = ST_RECOVER;
            cmd.incRetry = 1'b1;
          end
        end
        ST_RECOVER: if (stat.coolDone) nextState = (scFlag || otFlag) ? ST_HOLDOFF : ST_RUN;
        default:    nextState = ST_HOLDOFF;
      endcase
    end
    cmd.restartTmr = nextState != state;
    cmd.setFault   = (nextState == ST_DETECT) && (state != ST_DETECT);
    cmd.clrFault   = (nextState == ST_RUN) && (state != ST_RUN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HOLDOFF;
    else       state <= nextState;
  end

  // restart attempts only follow a completed trip, never a disable or supply loss
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                       autoOk <= 1'b0;
    else if (!permit || (state == ST_HOLDOFF && clearOk)) autoOk <= 1'b0;
    else if (state == ST_SOFTOFF && nextState == ST_HOLDOFF) autoOk <= 1'b1;
  end

  AST_HARD_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !(disableN && supplyOk) |=> state == ST_HOLDOFF);  // R2 R10
  AST_SC_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DETECT && !$past(otFlag)) |-> $past(stat.blankDone && pwmIn && scFlag));  // R3
  AST_DETECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_DETECT |=> (state == ST_SOFTOFF || state == ST_HOLDOFF));  // R4
  AST_SOFTOFF_CONFIRMED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLDOFF && $past(state) == ST_SOFTOFF)
      |-> ($past(offConfirm) || !$past(disableN && supplyOk)));  // R5

endmodule

// File: rtl/gate_fault_ctrl.sv
module gate_fault_ctrl
  import gfr_pkg::*;
#(
  parameter int unsigned BLANK_CYC   = 40,
  parameter int unsigned FAST_CYC    = 8,
  parameter int unsigned TAIL_CYC    = 60,
  parameter int unsigned CONFIRM_CYC = 200,
  parameter int unsigned COOL_CYC    = 5000,
  parameter int unsigned RETRY_MAX   = 3,
  parameter bit          AUTO_RETRY  = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwmIn,
  input  logic       scFlag,
  input  logic       otFlag,
  input  logic       disableN,
  input  logic       supplyOk,
  input  logic       clearReq,
  input  logic       offConfirm,
  output logic       driveOut,
  output logic       fastPull,
  output logic       softTail,
  output logic       clampEn,
  output logic       faultN,
  output logic [2:0] stateCode,
  output logic       confirmTimeout
);

  chanState_e state;
  dpCmd_t     cmd;
  dpStat_t    stat;
  logic       fastActive, tailActive, faultLatched, inSoftOff;

  gfr_ctrl #(.AUTO_RETRY(AUTO_RETRY)) uCtrl (
    .clk(clk), .rstN(rstN), .pwmIn(pwmIn), .scFlag(scFlag), .otFlag(otFlag),
    .disableN(disableN), .supplyOk(supplyOk), .clearReq(clearReq),
    .offConfirm(offConfirm), .stat(stat), .state(state), .cmd(cmd),
    .driveOut(driveOut)
  );

  gfr_datapath #(
    .BLANK_CYC(BLANK_CYC), .FAST_CYC(FAST_CYC), .TAIL_CYC(TAIL_CYC),
    .CONFIRM_CYC(CONFIRM_CYC), .COOL_CYC(COOL_CYC), .RETRY_MAX(RETRY_MAX)
  ) uData (
    .clk(clk), .rstN(rstN), .driveOut(driveOut), .inSoftOff(inSoftOff),
    .offConfirm(offConfirm), .cmd(cmd), .stat(stat), .fastActive(fastActive),
    .tailActive(tailActive), .faultLatched(faultLatched),
    .confirmTimeout(confirmTimeout)
  );

  assign inSoftOff = state == ST_SOFTOFF;
  assign fastPull  = inSoftOff && fastActive;
  assign softTail  = inSoftOff && tailActive;
  assign clampEn   = !driveOut && (state != ST_DETECT) && !inSoftOff;
  assign faultN    = !faultLatched;
  assign stateCode = state;

endmodule

// File: tb/gate_fault_ctrl_test.sv
module gate_fault_ctrl_test;

  localparam int BL = 3, FA = 2, TA = 3, CF = 4, CO = 5, RM = 2;
  localparam int TMAX = (FA + TA + CF > CO) ? FA + TA + CF : CO;

  logic clk = 1'b0, rstN = 1'b0;
  logic pwmIn = 0, scFlag = 0, otFlag = 0, disableN = 1, supplyOk = 1;
  logic clearReq = 0, offConfirm = 1;
  logic drv [2], fp [2], stl [2], cl [2], fn [2], to [2];
  logic [2:0] stc [2];

  int checks = 0, errors = 0;
  int mState [2], mTmr [2], mOn [2], mRetry [2];
  bit mFault [2], mTo [2], mAuto [2];

  always #5 clk = ~clk;

  gate_fault_ctrl #(.BLANK_CYC(BL), .FAST_CYC(FA), .TAIL_CYC(TA), .CONFIRM_CYC(CF),
    .COOL_CYC(CO), .RETRY_MAX(RM), .AUTO_RETRY(1'b1)) uut (
    .clk(clk), .rstN(rstN), .pwmIn(pwmIn), .scFlag(scFlag), .otFlag(otFlag),
    .disableN(disableN), .supplyOk(supplyOk), .clearReq(clearReq), .offConfirm(offConfirm),
    .driveOut(drv[0]), .fastPull(fp[0]), .softTail(stl[0]), .clampEn(cl[0]),
    .faultN(fn[0]), .stateCode(stc[0]), .confirmTimeout(to[0]));

  gate_fault_ctrl #(.BLANK_CYC(BL), .FAST_CYC(FA), .TAIL_CYC(TA), .CONFIRM_CYC(CF),
    .COOL_CYC(CO), .RETRY_MAX(RM), .AUTO_RETRY(1'b0)) uutLatch (
    .clk(clk), .rstN(rstN), .pwmIn(pwmIn), .scFlag(scFlag), .otFlag(otFlag),
    .disableN(disableN), .supplyOk(supplyOk), .clearReq(clearReq), .offConfirm(offConfirm),
    .driveOut(drv[1]), .fastPull(fp[1]), .softTail(stl[1]), .clampEn(cl[1]),
    .faultN(fn[1]), .stateCode(stc[1]), .confirmTimeout(to[1]));

  task automatic check(string tag, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", tag, nm, act, exp, $time);
    end
  endtask

  function automatic int expDrive(int i);
    return (mState[i] == 0 && pwmIn && disableN && supplyOk) ? 1 : 0;
  endfunction

  task automatic compareAll();
    for (int i = 0; i < 2; i++) begin
      int d = expDrive(i);
      check("R1", "driveOut", drv[i], d);
      check("R1", "stateCode", stc[i], mState[i]);
      check("R4", "fastPull", fp[i], (mState[i] == 2 && mTmr[i] < FA) ? 1 : 0);
      check("R4", "softTail", stl[i], (mState[i] == 2 && mTmr[i] >= FA && mTmr[i] < FA + TA) ? 1 : 0);
      check("R11", "clampEn", cl[i], (d == 0 && mState[i] != 1 && mState[i] != 2) ? 1 : 0);
      check("R12", "faultN", fn[i], mFault[i] ? 0 : 1);
      check("R13", "confirmTimeout", to[i], mTo[i] ? 1 : 0);
    end
  endtask

  task automatic modelStep();
    for (int i = 0; i < 2; i++) begin
      bit permit = disableN && supplyOk;
      bit clrOk = clearReq && permit && !scFlag && !otFlag;
      bit retryMode = (i == 0);
      int d = expDrive(i);
      int st = mState[i];
      int ns = st;
      if (!permit) ns = 3;
      else case (st)
        0: if ((d == 1 && mOn[i] == BL && scFlag) || otFlag) ns = 1;
        1: ns = 2;
        2: if (mTmr[i] >= FA + TA && offConfirm) ns = 3;
        3: if (clrOk) ns = 0;
           else if (retryMode && mAuto[i] && mRetry[i] < RM) ns = 4;
        4: if (mTmr[i] >= CO - 1) ns = (scFlag || otFlag) ? 3 : 0;
        default: ns = 3;
      endcase
      if (st == 3 && ns == 0) begin mTo[i] = 0; mRetry[i] = 0; end
      else if (st == 2 && mTmr[i] >= FA + TA + CF && !offConfirm) mTo[i] = 1;
      if (st == 3 && ns == 4) mRetry[i]++;
      if (ns == 1 && st != 1) mFault[i] = 1;
      else if (ns == 0 && st != 0) mFault[i] = 0;
      if (!permit || (st == 3 && clrOk)) mAuto[i] = 0;
      else if (st == 2 && ns == 3) mAuto[i] = 1;
      mTmr[i] = (ns != st) ? 0 : ((mTmr[i] < TMAX) ? mTmr[i] + 1 : mTmr[i]);
      mOn[i] = d ? ((mOn[i] < BL) ? mOn[i] + 1 : mOn[i]) : 0;
      mState[i] = ns;
    end
  endtask

  // called at a negedge with inputs already set
  task automatic tick();
    #1 compareAll();
    @(posedge clk);
    modelStep();
    @(negedge clk);
  endtask

  task automatic tickN(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2; i++) begin
      mState[i] = 3; mTmr[i] = 0; mOn[i] = 0; mRetry[i] = 0;
      mFault[i] = 0; mTo[i] = 0; mAuto[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R14 reset state
    check("R14", "reset state", stc[0], 3);
    check("R14", "reset faultN", fn[0], 1);
    check("R14", "reset timeout", to[0], 0);
    tickN(3);
    check("R14", "no retry before trip", stc[0], 3);

    // R9 clear refused while a flag is high
    clearReq = 1; scFlag = 1; tick();
    check("R9", "unqualified clear ignored", stc[0], 3);
    scFlag = 0; tick();
    check("R9", "qualified clear retry", stc[0], 0);
    check("R9", "qualified clear latch", stc[1], 0);
    clearReq = 0;

    // R3 blanking: flag while off and inside blanking ignored
    scFlag = 1; tickN(2);
    check("R3", "sc ignored while off", stc[0], 0);
    pwmIn = 1; tickN(BL);
    check("R3", "sc ignored in blanking", stc[0], 0);
    tick();
    check("R3", "sc trips after blanking", stc[0], 1);
    check("R12", "faultN on trip", fn[0], 0);
    scFlag = 0; offConfirm = 0; tick();
    check("R4", "detect then soft-off", stc[0], 2);
    tickN(FA + TA + CF + 2);
    check("R13", "timeout raised", to[0], 1);
    check("R5", "waits for confirm", stc[0], 2);
    offConfirm = 1; tick();
    check("R5", "confirm leads off", stc[0], 3);
    tick();
    check("R6", "retry starts", stc[0], 4);
    check("R8", "latch mode holds", stc[1], 3);
    tickN(CO);
    check("R7", "recovery to run", stc[0], 0);
    check("R13", "timeout sticky", to[0], 1);

    // R6 exhaustion: overtemperature stays high so recovery fails
    otFlag = 1; tickN(40);
    check("R6", "attempts exhausted", stc[0], 3);
    check("R12", "faultN held", fn[0], 0);
    otFlag = 0; tickN(6);
    check("R6", "still latched after limit", stc[0], 3);
    clearReq = 1; tick(); clearReq = 0;
    check("R9", "clear after exhaustion", stc[0], 0);
    check("R9", "clear resets timeout", to[0], 0);

    // R2 hard disable
    pwmIn = 1; disableN = 0; #1;
    check("R2", "disable cuts drive", drv[0], 0);
    tick();
    check("R2", "disable parks off", stc[0], 3);
    disableN = 1; tickN(4);
    check("R2", "no restart after disable", stc[0], 3);
    clearReq = 1; tick(); clearReq = 0;
    supplyOk = 0; #1;
    check("R10", "supply loss cuts drive", drv[0], 0);
    tick();
    check("R10", "supply loss parks off", stc[1], 3);
    supplyOk = 1; clearReq = 1; tick(); clearReq = 0;

    // constrained random traffic
    for (int n = 0; n < 6000; n++) begin
      if ($urandom % 4 == 0) pwmIn = ~pwmIn;
      scFlag = ($urandom % 12 == 0);
      if ($urandom % 60 == 0) otFlag = ~otFlag;
      disableN = ($urandom % 90 != 0);
      supplyOk = ($urandom % 120 != 0);
      clearReq = ($urandom % 15 == 0);
      offConfirm = ($urandom % 3 != 0);
      tick();
    end
    summary();
  end

endmodule